// File: doc/BRIEF.md
# Wrong-Execution Side Cache

This block pairs a direct-mapped L1 data array with a small fully associative side array. It keeps lines fetched by mispredicted work out of the L1. Every request carries a wrong-execution bit. The bit is set for a load issued down a mispredicted branch path, or from a speculative thread that is later aborted. The bit is still honoured after the load is known to be wrong, so such loads keep reaching memory and act as prefetches. A miss with the bit set places its line only in the side array, and a miss with the bit clear places its line only in the L1. Every lookup probes both arrays in the same cycle. A hit in either array answers one cycle after the request is accepted.

Misses are handled one at a time by a three-state controller:
- `S_IDLE` accepts a request. On a load miss it moves to `S_REQ`.
- `S_REQ` raises `mem_req_valid` for exactly one cycle and then moves to `S_WAIT`.
- `S_WAIT` holds until `fill_valid` arrives. It then writes the line into the array chosen by the wrong-execution bit, answers the load and returns to `S_IDLE`.

Stores carrying the wrong-execution bit are dropped without touching any state. Correct-path stores update a word in a line that is already present and never allocate.

Top module: `spec_side_cache`

## Requirements
- R1: After reset both arrays are empty, `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0. The first load to any line misses.
- R2: A load that hits in either array gives `resp_valid`=1 and `resp_hit`=1 one cycle after acceptance. `resp_side` is 0 for an L1 hit and 1 for a side-array hit, and `resp_data` is the addressed word. This holds for both values of the wrong-execution bit.
- R3: On a load miss, `mem_req_valid` is 1 for exactly the one cycle after acceptance, with `mem_req_line` = `req_addr[15:2]`. `req_ready` stays 0 from that cycle until the miss response.
- R4: A correct-path miss fills only the L1, at set `line[3:0]`, replacing whatever that set held. Its response has `resp_side`=0.
- R5: A wrong-execution miss fills only the side array, and its response has `resp_side`=1. The L1 line in the same set stays resident, and a line is never held in both arrays.
- R6: A miss is answered in the cycle after `fill_valid` is taken in `S_WAIT`, with `resp_hit`=0. `resp_data` is word `req_addr[1:0]` of `fill_data`, where word w sits at bits [32w+31:32w].
- R7: `fill_valid` outside `S_WAIT` is ignored: there is no response and no line is written.
- R8: The side array holds 8 lines with LRU replacement. An empty entry is used before any valid one. Every side hit (from either path) and every fill makes that entry the most recently used. A fill to a line already present only refreshes its LRU position.
- R9: A store with the wrong-execution bit set is answered with `resp_hit`=0 and changes no data, tag or LRU state.
- R10: A correct-path store that hits writes `req_wdata` into the array holding the line and answers with `resp_hit`=1. A store that misses answers with `resp_hit`=0, issues no memory request and allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (controller in `S_IDLE`) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_wrong | input | 1 | Request comes from wrong-path or aborted-thread execution |
| req_addr | input | 16 | Word address; bits [1:0] pick the word in a line |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Response present for one cycle |
| resp_hit | output | 1 | Request hit (load or store) |
| resp_side | output | 1 | Data came from, or was placed in, the side array |
| resp_data | output | 32 | Load data |
| mem_req_valid | output | 1 | Line request to the next level |
| mem_req_line | output | 14 | Line address requested |
| fill_valid | input | 1 | Line returned from the next level |
| fill_data | input | 128 | Returned line, word 0 in the low bits |

## Verification
The assertions assume three things about the inputs:
- A request is presented only while `req_ready` is high.
- `fill_valid` pulses for a single cycle.
- At most one line is outstanding.

Under these assumptions the two arrays never hold the same line, and a side-array touch never meets a fill in the same cycle. The stimulus drives every request on the falling edge and waits for `req_ready`. It returns each fill only after it has seen the memory request. The only deliberate stray fill is the one that checks R7.

// File: rtl/wec_pkg.sv
package wec_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2
    } miss_state_e;
endpackage

// File: rtl/wec_miss_fsm.sv
module wec_miss_fsm
    import wec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_miss,
    input  logic fill_valid,
    output logic req_ready,
    output logic mem_req_valid,
    output logic fill_take
);
    miss_state_e state_q, state_d;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_miss) state_d = S_REQ;
            S_REQ:   state_d = S_WAIT;
            S_WAIT:  if (fill_valid) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        fill_take     = 1'b0;
        unique case (state_q)
            S_IDLE:  req_ready = 1'b1;
            S_REQ:   mem_req_valid = 1'b1;
            S_WAIT:  fill_take = fill_valid;
            default: req_ready = 1'b0;
        endcase
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid && !req_ready); // R3
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_miss |-> req_ready); // R3
endmodule

// File: rtl/wec_l1_array.sv
module wec_l1_array #(
    parameter int LINE_ADDR_W = 14,
    parameter int SETS        = 16,
    parameter int WORDS       = 4,
    parameter int DATA_W      = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LINE_ADDR_W-1:0]   lk_line,
    input  logic [$clog2(WORDS)-1:0] lk_off,
    output logic                     lk_hit,
    output logic [DATA_W-1:0]        lk_word,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_word,
    input  logic                     fill_en,
    input  logic [LINE_ADDR_W-1:0]   fill_line,
    input  logic [WORDS*DATA_W-1:0]  fill_data
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = LINE_ADDR_W - IDX_W;
    localparam int LINE_W = WORDS * DATA_W;

    logic              valid_q [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS];
    logic [LINE_W-1:0] data_q  [SETS];

    logic [IDX_W-1:0] lk_idx, fill_idx;
    assign lk_idx   = lk_line[IDX_W-1:0];
    assign fill_idx = fill_line[IDX_W-1:0];

    assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_line[LINE_ADDR_W-1:IDX_W]);
    assign lk_word = data_q[lk_idx][int'(lk_off)*DATA_W +: DATA_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) valid_q[i] <= 1'b0;
        end else if (fill_en) begin
            valid_q[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_line[LINE_ADDR_W-1:IDX_W];
            data_q[fill_idx] <= fill_data;
        end else if (wr_en) begin
            data_q[lk_idx][int'(lk_off)*DATA_W +: DATA_W] <= wr_word;
        end
    end

    AST_L1_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && wr_en)); // R10
    AST_L1_WR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> lk_hit); // R10
endmodule

// File: rtl/wec_side_array.sv
module wec_side_array #(
    parameter int LINE_ADDR_W = 14,
    parameter int ENTRIES     = 8,
    parameter int WORDS       = 4,
    parameter int DATA_W      = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LINE_ADDR_W-1:0]   lk_line,
    input  logic [$clog2(WORDS)-1:0] lk_off,
    input  logic                     lk_touch,
    output logic                     lk_hit,
    output logic [DATA_W-1:0]        lk_word,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_word,
    input  logic                     fill_en,
    input  logic [LINE_ADDR_W-1:0]   fill_line,
    input  logic [WORDS*DATA_W-1:0]  fill_data
);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int LINE_W = WORDS * DATA_W;

    logic                   valid_q [ENTRIES];
    logic [LINE_ADDR_W-1:0] tag_q   [ENTRIES];
    logic [IDX_W-1:0]       age_q   [ENTRIES];
    logic [LINE_W-1:0]      data_q  [ENTRIES];

    logic [ENTRIES-1:0] lk_match, fill_match, age_zero;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g]   = valid_q[g] && (tag_q[g] == lk_line);
        assign fill_match[g] = valid_q[g] && (tag_q[g] == fill_line);
        assign age_zero[g]   = (age_q[g] == '0);
    end

    logic [IDX_W-1:0] lk_idx, fill_idx, victim, touch_idx;
    logic             fill_hit, found, touch_en;

    always_comb begin
        lk_idx   = '0;
        fill_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i])   lk_idx   = IDX_W'(i);
            if (fill_match[i]) fill_idx = IDX_W'(i);
        end
    end

    // victim: lowest empty entry, else least recently used
    always_comb begin
        victim = '0;
        found  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_q[i] && !found) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (age_q[i] == IDX_W'(ENTRIES - 1)) victim = IDX_W'(i);
            end
        end
    end

    assign lk_hit   = |lk_match;
    assign fill_hit = |fill_match;
    assign lk_word  = data_q[lk_idx][int'(lk_off)*DATA_W +: DATA_W];
    assign touch_en = fill_en || (lk_touch && lk_hit);
    assign touch_idx = fill_en ? (fill_hit ? fill_idx : victim) : lk_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                valid_q[i] <= 1'b0;
                age_q[i]   <= IDX_W'(i);
            end
        end else begin
            if (fill_en && !fill_hit) valid_q[victim] <= 1'b1;
            if (touch_en) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (IDX_W'(i) == touch_idx)
                        age_q[i] <= '0;
                    else if (age_q[i] < age_q[touch_idx])
                        age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !fill_hit) begin
            tag_q[victim]  <= fill_line;
            data_q[victim] <= fill_data;
        end else if (wr_en && lk_hit) begin
            data_q[lk_idx][int'(lk_off)*DATA_W +: DATA_W] <= wr_word;
        end
    end

    AST_SIDE_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R8
    AST_SIDE_ONE_MRU: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(age_zero) == 1); // R8
    AST_SIDE_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && (lk_touch || wr_en))); // R8
endmodule

// File: rtl/spec_side_cache.sv
module spec_side_cache #(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 32,
    parameter int LINE_WORDS   = 4,
    parameter int L1_SETS      = 16,
    parameter int SIDE_ENTRIES = 8
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     req_valid,
    output logic                                     req_ready,
    input  logic                                     req_store,
    input  logic                                     req_wrong,
    input  logic [ADDR_W-1:0]                        req_addr,
    input  logic [DATA_W-1:0]                        req_wdata,
    output logic                                     resp_valid,
    output logic                                     resp_hit,
    output logic                                     resp_side,
    output logic [DATA_W-1:0]                        resp_data,
    output logic                                     mem_req_valid,
    output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]     mem_req_line,
    input  logic                                     fill_valid,
    input  logic [LINE_WORDS*DATA_W-1:0]             fill_data
);
    localparam int OFF_W       = $clog2(LINE_WORDS);
    localparam int LINE_ADDR_W = ADDR_W - OFF_W;

    logic [LINE_ADDR_W-1:0] lk_line, pend_line;
    logic [OFF_W-1:0]       lk_off, pend_off;
    logic                   pend_wrong;
    logic                   acc, l1_hit, side_hit, any_hit, load_miss;
    logic                   st_ok, wrong_st, fill_take;
    logic [DATA_W-1:0]      l1_word, side_word, fill_word;

    assign lk_line   = req_addr[ADDR_W-1:OFF_W];
    assign lk_off    = req_addr[OFF_W-1:0];
    assign acc       = req_valid && req_ready;
    assign any_hit   = l1_hit || side_hit;
    assign load_miss = acc && !req_store && !any_hit;
    assign st_ok     = acc && req_store && !req_wrong;
    assign wrong_st  = acc && req_store && req_wrong;
    assign fill_word = fill_data[int'(pend_off)*DATA_W +: DATA_W];
    assign mem_req_line = pend_line;

    wec_miss_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_miss    (load_miss),
        .fill_valid    (fill_valid),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .fill_take     (fill_take)
    );

    wec_l1_array #(
        .LINE_ADDR_W (LINE_ADDR_W),
        .SETS        (L1_SETS),
        .WORDS       (LINE_WORDS),
        .DATA_W      (DATA_W)
    ) u_l1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_line   (lk_line),
        .lk_off    (lk_off),
        .lk_hit    (l1_hit),
        .lk_word   (l1_word),
        .wr_en     (st_ok && l1_hit),
        .wr_word   (req_wdata),
        .fill_en   (fill_take && !pend_wrong),
        .fill_line (pend_line),
        .fill_data (fill_data)
    );

    wec_side_array #(
        .LINE_ADDR_W (LINE_ADDR_W),
        .ENTRIES     (SIDE_ENTRIES),
        .WORDS       (LINE_WORDS),
        .DATA_W      (DATA_W)
    ) u_side (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_line   (lk_line),
        .lk_off    (lk_off),
        .lk_touch  (acc && !wrong_st),
        .lk_hit    (side_hit),
        .lk_word   (side_word),
        .wr_en     (st_ok && side_hit),
        .wr_word   (req_wdata),
        .fill_en   (fill_take && pend_wrong),
        .fill_line (pend_line),
        .fill_data (fill_data)
    );

    // pending miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_line  <= '0;
            pend_off   <= '0;
            pend_wrong <= 1'b0;
        end else if (load_miss) begin
            pend_line  <= lk_line;
            pend_off   <= lk_off;
            pend_wrong <= req_wrong;
        end
    end

    // response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_side  <= 1'b0;
            resp_data  <= '0;
        end else if (acc) begin
            resp_valid <= !load_miss;
            resp_hit   <= any_hit && !wrong_st;
            resp_side  <= side_hit && !wrong_st;
            resp_data  <= (req_store || !any_hit) ? '0 : (l1_hit ? l1_word : side_word);
        end else if (fill_take) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            resp_side  <= pend_wrong;
            resp_data  <= fill_word;
        end else begin
            resp_valid <= 1'b0;
        end
    end

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> !(l1_hit && side_hit)); // R5
    AST_HIT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_store && any_hit) |=> resp_valid && resp_hit); // R2
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        load_miss |=> !req_ready && mem_req_valid); // R3
    AST_FILL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        fill_take |=> resp_valid && !resp_hit && req_ready); // R6
    AST_STRAY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_take && !acc) |=> !resp_valid); // R7
    AST_WRONG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wrong_st |=> resp_valid && !resp_hit && !resp_side); // R9
endmodule

// File: tb/tb_spec_side_cache.sv
module tb_spec_side_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_store = 1'b0;
    logic         req_wrong = 1'b0;
    logic [15:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         resp_valid, resp_hit, resp_side;
    logic [31:0]  resp_data;
    logic         mem_req_valid;
    logic [13:0]  mem_req_line;
    logic         fill_valid = 1'b0;
    logic [127:0] fill_data = '0;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spec_side_cache dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_store(req_store), .req_wrong(req_wrong), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_side(resp_side), .resp_data(resp_data), .mem_req_valid(mem_req_valid),
        .mem_req_line(mem_req_line), .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [31:0] memw(input logic [13:0] ln, input logic [1:0] w);
        return {2'b10, ln, 14'h0, w};
    endfunction

    function automatic logic [127:0] memline(input logic [13:0] ln);
        return {memw(ln, 2'd3), memw(ln, 2'd2), memw(ln, 2'd1), memw(ln, 2'd0)};
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic send(input logic st, input logic wr, input logic [15:0] a, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_wrong = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_store = 1'b0; req_wrong = 1'b0;
    endtask

    task automatic do_load(input logic wr, input logic [15:0] a, input logic eh, input logic es,
                           input logic [31:0] ed, input string rq);
        send(1'b0, wr, a, '0);
        if (eh) begin
            chk(rq, "hit resp_valid", 32'(resp_valid), 1);
            chk(rq, "hit resp_hit", 32'(resp_hit), 1);
            chk(rq, "hit resp_side", 32'(resp_side), 32'(es));
            chk(rq, "hit resp_data", resp_data, ed);
        end else begin
            chk("R3", "miss req pulse", 32'(mem_req_valid), 1);
            chk("R3", "miss line", 32'(mem_req_line), 32'(a[15:2]));
            chk("R3", "miss ready low", 32'(req_ready), 0);
            chk(rq, "miss no early resp", 32'(resp_valid), 0);
            @(negedge clk);
            chk("R3", "req pulse ends", 32'(mem_req_valid), 0);
            fill_valid = 1'b1; fill_data = memline(a[15:2]);
            @(negedge clk);
            fill_valid = 1'b0;
            chk("R6", "fill resp_valid", 32'(resp_valid), 1);
            chk("R6", "fill resp_hit", 32'(resp_hit), 0);
            chk(rq, "fill resp_side", 32'(resp_side), 32'(es));
            chk("R6", "fill resp_data", resp_data, ed);
        end
    endtask

    task automatic do_store(input logic wr, input logic [15:0] a, input logic [31:0] wd,
                            input logic eh, input string rq);
        send(1'b1, wr, a, wd);
        chk(rq, "store resp_valid", 32'(resp_valid), 1);
        chk(rq, "store resp_hit", 32'(resp_hit), 32'(eh));
        chk(rq, "store no mem req", 32'(mem_req_valid), 0);
        chk(rq, "store ready", 32'(req_ready), 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // {wrong, addr[15:0], exp_hit, exp_side}
    localparam int NV = 10;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 16'h0010, 1'b0, 1'b0},  // R4 correct miss into L1 set 4
        {1'b0, 16'h0011, 1'b1, 1'b0},  // R2 L1 hit
        {1'b1, 16'h0050, 1'b0, 1'b1},  // R5 wrong miss, same set, side only
        {1'b0, 16'h0012, 1'b1, 1'b0},  // R5 L1 line survived
        {1'b0, 16'h0053, 1'b1, 1'b1},  // R2 correct hit in side
        {1'b1, 16'h0013, 1'b1, 1'b0},  // R2 wrong load hits L1
        {1'b0, 16'h0100, 1'b0, 1'b0},  // R4 miss set 0
        {1'b0, 16'h0140, 1'b0, 1'b0},  // R4 conflict in set 0
        {1'b0, 16'h0101, 1'b0, 1'b0},  // R4 evicted line misses again
        {1'b1, 16'h0051, 1'b1, 1'b1}   // R2 wrong hit in side
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", "ready after reset", 32'(req_ready), 1);
        chk("R1", "resp_valid after reset", 32'(resp_valid), 0);
        chk("R1", "mem_req after reset", 32'(mem_req_valid), 0);

        for (int i = 0; i < NV; i++) begin
            do_load(VEC[i][18], VEC[i][17:2], VEC[i][1], VEC[i][0],
                    memw(VEC[i][17:4], VEC[i][3:2]), "table");
        end

        // R7 stray fill ignored
        @(negedge clk);
        fill_valid = 1'b1; fill_data = memline(14'h060);
        @(negedge clk);
        fill_valid = 1'b0;
        chk("R7", "stray fill no resp", 32'(resp_valid), 0);
        chk("R7", "stray fill ready", 32'(req_ready), 1);
        do_load(1'b0, 16'h0180, 1'b0, 1'b0, memw(14'h060, 2'd0), "R7");

        // R10 / R9 stores
        do_store(1'b0, 16'h0011, 32'hDEAD0001, 1'b1, "R10");
        do_load(1'b0, 16'h0011, 1'b1, 1'b0, 32'hDEAD0001, "R10");
        do_store(1'b1, 16'h0011, 32'h0BAD0BAD, 1'b0, "R9");
        do_load(1'b0, 16'h0011, 1'b1, 1'b0, 32'hDEAD0001, "R9");
        do_store(1'b1, 16'h0052, 32'h0BAD0BAD, 1'b0, "R9");
        do_load(1'b0, 16'h0052, 1'b1, 1'b1, memw(14'h014, 2'd2), "R9");
        do_store(1'b0, 16'h0052, 32'h5EED0002, 1'b1, "R10");
        do_load(1'b0, 16'h0052, 1'b1, 1'b1, 32'h5EED0002, "R10");
        do_store(1'b0, 16'h0200, 32'h12345678, 1'b0, "R10");
        do_load(1'b0, 16'h0200, 1'b0, 1'b0, memw(14'h080, 2'd0), "R10");

        // R1 reset clears both arrays
        do_reset();
        chk("R1", "ready after 2nd reset", 32'(req_ready), 1);
        chk("R1", "resp_valid after 2nd reset", 32'(resp_valid), 0);
        do_load(1'b0, 16'h0052, 1'b0, 1'b0, memw(14'h014, 2'd2), "R1");
        do_load(1'b0, 16'h0011, 1'b0, 1'b0, memw(14'h004, 2'd1), "R1");

        // R8 LRU over 8 side entries
        for (int k = 0; k < 8; k++) begin
            logic [13:0] ln;
            ln = 14'h100 + 14'(k);
            do_load(1'b1, {ln, 2'b00}, 1'b0, 1'b1, memw(ln, 2'd0), "R8");
        end
        do_load(1'b0, {14'h100, 2'b01}, 1'b1, 1'b1, memw(14'h100, 2'd1), "R8");
        do_load(1'b1, {14'h108, 2'b00}, 1'b0, 1'b1, memw(14'h108, 2'd0), "R8");
        do_load(1'b0, {14'h100, 2'b10}, 1'b1, 1'b1, memw(14'h100, 2'd2), "R8");
        do_load(1'b0, {14'h102, 2'b00}, 1'b1, 1'b1, memw(14'h102, 2'd0), "R8");
        do_load(1'b0, {14'h101, 2'b11}, 1'b0, 1'b0, memw(14'h101, 2'd3), "R8");
        do_load(1'b1, {14'h103, 2'b00}, 1'b1, 1'b1, memw(14'h103, 2'd0), "R8");
        do_load(1'b1, {14'h10A, 2'b00}, 1'b0, 1'b1, memw(14'h10A, 2'd0), "R8");
        do_load(1'b0, {14'h104, 2'b00}, 1'b0, 1'b0, memw(14'h104, 2'd0), "R8");
        do_load(1'b0, {14'h105, 2'b01}, 1'b1, 1'b1, memw(14'h105, 2'd1), "R8");
        do_load(1'b0, {14'h108, 2'b11}, 1'b1, 1'b1, memw(14'h108, 2'd3), "R8");
        do_load(1'b0, {14'h103, 2'b10}, 1'b1, 1'b1, memw(14'h103, 2'd2), "R8");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule